// File: doc/BRIEF.md
# EEPROM Write Staging Controller

This block sits between the byte-level front end of a serial EEPROM and its storage array. A write transaction opens with a start pulse carrying the first byte address. Data bytes then arrive one per strobe and are held in an eight-entry row buffer. When the transaction closes with a stop event, the staged bytes are written to the array, one strobe per staged byte. The block then stays busy for a programmable number of clock cycles, which stands in for the self-timed programming time of the memory cells.

Two bulk modes are chosen by the `mode_multi` pin, which is sampled when the transaction opens.

- **Page mode** (`mode_multi` = 0) keeps every byte inside the eight-byte row of the start address. The offset inside the row wraps, so later bytes can overwrite earlier ones.
- **Multibyte mode** (`mode_multi` = 1) writes to linearly incrementing addresses. It accepts up to four bytes, or eight bytes when the start address is row aligned. The programming time doubles when the written addresses leave one four-byte group.

A write-lock pin sampled at the stop event cancels the commit entirely.

The controller has four states:

- **ST_IDLE**: waits for a start pulse. IDLE→COLLECT on `wr_start`.
- **ST_COLLECT**: stages bytes. COLLECT→COLLECT on a new `wr_start`, which restarts the transaction. COLLECT→COMMIT on `stop_evt` when at least one byte is staged and `wc_lock` is low. COLLECT→IDLE on `stop_evt` when the buffer is empty or `wc_lock` is high.
- **ST_COMMIT**: walks the eight buffer slots, one per cycle, and strobes the array for each occupied slot. COMMIT→PROGRAM after the eighth slot.
- **ST_PROGRAM**: counts down the programming time. PROGRAM→IDLE when the timer expires.

Top module: `eeprom_write_stager`

## Requirements
- R1: After reset, `busy` and `arr_we` are low. No array write occurs until a transaction with at least one byte ends with `stop_evt`.
- R2: In page mode, byte number i of a transaction goes to the address whose upper bits (above bit 2) equal those of the start address and whose low three bits are (start[2:0] + i) mod 8. A later byte that lands on an occupied slot replaces the earlier one, so at most eight bytes are written.
- R3: In multibyte mode, byte number i goes to (start + i) mod 2^ADDR_W. Only the first 4 bytes are kept, or the first 8 bytes when start[2:0] = 0. Further bytes are ignored.
- R4: A single-byte transaction writes that byte to the start address in either mode, with the same busy duration.
- R5: After `stop_evt`, `arr_we` pulses exactly once per distinct staged address, with `arr_addr` and `arr_wdata` valid in that cycle. All of these pulses fall inside the busy window.
- R6: `busy` rises in the cycle after the stop event and stays high for 8 + PROG_CYC cycles. In multibyte mode it stays high for 8 + 2*PROG_CYC cycles instead when bits [ADDR_W-1:2] of the first and last kept addresses differ.
- R7: If `wc_lock` is high when `stop_evt` arrives, no array write occurs and `busy` stays low.
- R8: A `stop_evt` with no byte staged causes no array write and leaves `busy` low.
- R9: While `busy` is high, `wr_start`, `byte_vld` and `stop_evt` are ignored. No extra write occurs, and the busy window is not extended.
- R10: The mode is captured at `wr_start`. A change on `mode_multi` during the transaction does not alter where its bytes are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | One-cycle pulse that opens a write transaction |
| wr_addr | input | ADDR_W | Start byte address, sampled with `wr_start` |
| byte_vld | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | DATA_W | Data byte qualified by `byte_vld` |
| stop_evt | input | 1 | One-cycle pulse that closes the transaction |
| mode_multi | input | 1 | 1 selects multibyte mode, 0 selects page mode |
| wc_lock | input | 1 | 1 suppresses the commit (write-locked), 0 allows it |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | High during the commit walk and the programming time |

## Verification
A wrong slot pointer or count in the collect state shows at the ports only after the stop event, during the eight-cycle commit walk. It appears as a write to an address outside the expected row or group, as data from an overwritten byte, or as the wrong number of `arr_we` pulses. A wrong long-cycle decision or a timer fault appears later, as a busy window that ends PROG_CYC cycles too early or too late. A state machine that leaves COLLECT on a locked or empty stop appears at once, as `busy` rising in the cycle after the stop.

// File: rtl/wstg_pkg.sv
package wstg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_PROGRAM
    } wstg_state_e;

    localparam int ROW_LEN   = 8;
    localparam int ROW_LSB   = 3;
    localparam int GRP_LSB   = 2;
    localparam int MB_SHORT  = 4;
    localparam int MB_LONG   = 8;
    localparam int CNT_W     = 4;

endpackage

// File: rtl/wstg_admit.sv
module wstg_admit
    import wstg_pkg::*;
(
    input  logic                 mode_multi,
    input  logic [ROW_LSB-1:0]   base_lo,
    input  logic [CNT_W-1:0]     cnt,
    output logic                 admit,
    output logic [ROW_LSB-1:0]   slot
);
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (base_lo == '0) ? CNT_W'(MB_LONG) : CNT_W'(MB_SHORT);
        if (mode_multi) begin
            admit = (cnt < limit);
            slot  = cnt[ROW_LSB-1:0];
        end else begin
            admit = 1'b1;
            slot  = base_lo + cnt[ROW_LSB-1:0];
        end
    end

endmodule

// File: rtl/wstg_stage_buf.sv
module wstg_stage_buf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DEPTH-1:0]  occ_q;
    logic [DATA_W-1:0] dat_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                occ_q[g] <= 1'b0;
                dat_q[g] <= '0;
            end else if (clear) begin
                occ_q[g] <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                occ_q[g] <= 1'b1;
                dat_q[g] <= wr_data;
            end
        end
    end

    assign rd_data   = dat_q[rd_slot];
    assign rd_valid  = occ_q[rd_slot];
    assign any_valid = |occ_q;

    // R2: a staged byte occupies its slot with its data on the next cycle
    a_r2_slot_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (occ_q[$past(wr_slot)] && dat_q[$past(wr_slot)] == $past(wr_data)));

    // R8: clearing leaves no slot occupied
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid);

endmodule

// File: rtl/wstg_prog_timer.sv
module wstg_prog_timer #(
    parameter int PROG_CYC = 500000,
    localparam int TW = $clog2(2 * PROG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_cyc,
    output logic done
);
    logic [TW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= long_cyc ? TW'(2 * PROG_CYC - 1) : TW'(PROG_CYC - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);

    // R6: the count never exceeds the doubled programming time
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= TW'(2 * PROG_CYC - 1)));

    // R6: an expiring timer is idle on the following cycle unless reloaded
    a_r6_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !run_q);

endmodule

// File: rtl/eeprom_write_stager.sv
module eeprom_write_stager
    import wstg_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8,
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    input  logic              mode_multi,
    input  logic              wc_lock,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy
);
    localparam int LAST_SLOT = ROW_LEN - 1;

    wstg_state_e         state_q, state_d;
    logic [ADDR_W-1:0]   base_q;
    logic                mode_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [ROW_LSB-1:0]  idx_q;

    logic                start_take, byte_take, stop_seen;
    logic                adm_ok;
    logic [ROW_LSB-1:0]  adm_slot;
    logic [DATA_W-1:0]   slot_data;
    logic                slot_valid, any_valid;
    logic                tmr_load, tmr_done, long_cyc;
    logic [ADDR_W-1:0]   last_addr;

    // ---------------- sub-blocks ----------------
    wstg_admit u_admit (
        .mode_multi (mode_q),
        .base_lo    (base_q[ROW_LSB-1:0]),
        .cnt        (cnt_q),
        .admit      (adm_ok),
        .slot       (adm_slot)
    );

    wstg_stage_buf #(.DEPTH(ROW_LEN), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_take),
        .wr_en     (byte_take),
        .wr_slot   (adm_slot),
        .wr_data   (byte_data),
        .rd_slot   (idx_q),
        .rd_data   (slot_data),
        .rd_valid  (slot_valid),
        .any_valid (any_valid)
    );

    wstg_prog_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .long_cyc (long_cyc),
        .done     (tmr_done)
    );

    // ---------------- event qualification ----------------
    always_comb begin
        start_take = wr_start && (state_q == ST_IDLE || state_q == ST_COLLECT);
        stop_seen  = (state_q == ST_COLLECT) && !wr_start && stop_evt;
        byte_take  = (state_q == ST_COLLECT) && !wr_start && !stop_evt
                     && byte_vld && adm_ok;
        last_addr  = base_q + ADDR_W'(cnt_q) - 1'b1;
        long_cyc   = mode_q &&
                     (last_addr[ADDR_W-1:GRP_LSB] != base_q[ADDR_W-1:GRP_LSB]);
        tmr_load   = (state_q == ST_COMMIT) && (idx_q == ROW_LSB'(LAST_SLOT));
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (wr_start)
                    state_d = ST_COLLECT;
                else if (stop_evt)
                    state_d = (any_valid && !wc_lock) ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (idx_q == ROW_LSB'(LAST_SLOT)) state_d = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- transaction registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (start_take) begin
                base_q <= wr_addr;
                mode_q <= mode_multi;
                cnt_q  <= '0;
            end else if (byte_take) begin
                cnt_q  <= cnt_q + 1'b1;
            end
            if (state_q == ST_COMMIT) idx_q <= idx_q + 1'b1;
            else                      idx_q <= '0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = '0;
        arr_wdata = '0;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: begin
                busy = 1'b0;
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                arr_we    = slot_valid;
                arr_wdata = slot_data;
                arr_addr  = mode_q ? (base_q + ADDR_W'(idx_q))
                                   : {base_q[ADDR_W-1:ROW_LSB], idx_q};
            end
            ST_PROGRAM: begin
                busy = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    // R1: no array write can appear outside the busy window
    a_r1_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R3: multibyte staging never keeps more bytes than its limit
    a_r3_multi_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && mode_q) |->
        (cnt_q <= ((base_q[ROW_LSB-1:0] == '0) ? CNT_W'(MB_LONG) : CNT_W'(MB_SHORT))));

    // R5: page-mode writes stay inside the start row
    a_r5_page_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !mode_q) |-> (arr_addr[ADDR_W-1:ROW_LSB] == base_q[ADDR_W-1:ROW_LSB]));

    // R7: a locked stop never opens a busy window
    a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && wc_lock) |=> !busy);

    // R8: an empty stop never opens a busy window
    a_r8_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !any_valid) |=> !busy);

    // R9: a start pulse while busy does not reopen collection
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_start) |=> (state_q != ST_COLLECT));

    // R10: the captured mode is held throughout collection
    a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && !wr_start) |=> $stable(mode_q));

endmodule

// File: tb/sim_eeprom_write_stager.sv
module sim_eeprom_write_stager;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int T  = 20;
    localparam int MEMSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_start = 1'b0, byte_vld = 1'b0, stop_evt = 1'b0;
    logic mode_multi = 1'b0, wc_lock = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] byte_data = '0;
    logic arr_we, busy;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;

    always #10 clk = ~clk;

    eeprom_write_stager #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
        .mode_multi(mode_multi), .wc_lock(wc_lock), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy));

    int errors = 0, checks = 0, tn = 0;
    int wr_cnt = 0, busy_cnt = 0;
    logic [DW-1:0] seen_mem [MEMSZ];
    logic [DW-1:0] exp_mem  [MEMSZ];
    bit finished = 1'b0;

    // stimulus table: {mode_multi, wc_lock, start address, byte count}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 9'h010, 4'd1},   // R4 page single
        {1'b1, 1'b0, 9'h023, 4'd1},   // R4 multi single
        {1'b0, 1'b0, 9'h045, 4'd5},   // R2 wrap in row
        {1'b0, 1'b0, 9'h0F8, 4'd8},   // R2 full row
        {1'b0, 1'b0, 9'h101, 4'd11},  // R2 overwrite
        {1'b1, 1'b0, 9'h031, 4'd4},   // R3/R6 group cross
        {1'b1, 1'b0, 9'h030, 4'd4},   // R3/R6 one group
        {1'b1, 1'b0, 9'h035, 4'd6},   // R3 extras ignored
        {1'b1, 1'b0, 9'h040, 4'd8},   // R3 aligned eight
        {1'b1, 1'b0, 9'h050, 4'd10},  // R3 aligned, extras ignored
        {1'b0, 1'b1, 9'h060, 4'd3},   // R7 locked
        {1'b1, 1'b0, 9'h070, 4'd0},   // R8 empty
        {1'b1, 1'b0, 9'h1FE, 4'd3},   // R3 address wrap
        {1'b0, 1'b0, 9'h1FE, 4'd3}    // R2 row wrap at top
    };

    function automatic logic [DW-1:0] dat(input logic [AW-1:0] b, input int i, input int k);
        return DW'(int'(b) * 3 + i * 29 + k * 11 + 1);
    endfunction

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (arr_we) begin
            wr_cnt++;
            seen_mem[arr_addr] = arr_wdata;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic m, input logic w, input logic [AW-1:0] b,
                           input int n, input bit flip, input bit disturb, input string tag);
        int exp_wr, exp_busy, acc, lim, bad;
        logic [AW-1:0] a, last;
        tn++;
        lim = (b[2:0] == 3'd0) ? 8 : 4;
        acc = m ? ((n > lim) ? lim : n) : ((n > 8) ? 8 : n);
        if (w || n == 0) begin
            exp_wr = 0; exp_busy = 0;
        end else begin
            exp_wr = acc;
            last = b + AW'(acc - 1);
            exp_busy = 8 + ((m && last[AW-1:2] != b[AW-1:2]) ? 2 * T : T);
            for (int i = 0; i < n; i++) begin
                if (m) begin
                    if (i < lim) begin a = b + AW'(i); exp_mem[a] = dat(b, i, tn); end
                end else begin
                    a = {b[AW-1:3], 3'(b[2:0] + 3'(i))};
                    exp_mem[a] = dat(b, i, tn);
                end
            end
        end
        @(negedge clk);
        wr_cnt = 0; busy_cnt = 0;
        mode_multi = m; wc_lock = w; wr_addr = b; wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        if (flip) mode_multi = ~m;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = dat(b, i, tn);
            @(negedge clk);
        end
        byte_vld = 1'b0; stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        if (disturb) begin
            @(negedge clk);
            wr_start = 1'b1; wr_addr = 9'h100;
            @(negedge clk);
            wr_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h5A;
            @(negedge clk);
            byte_vld = 1'b0; stop_evt = 1'b1;
            @(negedge clk);
            stop_evt = 1'b0;
        end
        repeat (8 + 2 * T + 6) @(negedge clk);
        check(tag, "write strobes (R5)", wr_cnt, exp_wr);
        check(tag, "busy cycles (R6)", busy_cnt, exp_busy);
        bad = 0;
        for (int i = 0; i < MEMSZ; i++) if (seen_mem[i] !== exp_mem[i]) bad++;
        check(tag, "array mismatches", bad, 0);
        wc_lock = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin seen_mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "arr_we after reset", int'(arr_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "busy idle", int'(busy), 0);

        for (int v = 0; v < NV; v++) begin
            logic [14:0] e;
            string tag;
            e = VEC[v];
            if (e[13])            tag = "R7";
            else if (e[3:0] == 0) tag = "R8";
            else if (e[3:0] == 1) tag = "R4";
            else if (e[14])       tag = "R3";
            else                  tag = "R2";
            run_txn(e[14], e[13], e[12:4], int'(e[3:0]), 1'b0, 1'b0, tag);
        end

        // R10: mode flipped after start, page placement kept
        run_txn(1'b0, 1'b0, 9'h0C6, 4, 1'b1, 1'b0, "R10");
        // R10: multibyte captured, flipped to page mid-transaction
        run_txn(1'b1, 1'b0, 9'h0D3, 4, 1'b1, 1'b0, "R10");
        // R9: traffic during busy is ignored
        run_txn(1'b0, 1'b0, 9'h0E2, 3, 1'b0, 1'b1, "R9");
        // R9: block still accepts a normal transaction afterwards
        run_txn(1'b1, 1'b0, 9'h120, 2, 1'b0, 1'b0, "R9");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule